// File: doc/BRIEF.md
# Reserved-Opcode Execution Slice

This block sits beside the main datapath of an 8-bit accumulator CPU and takes over the opcodes that would otherwise halt the processor. When the fetch logic hands it an opcode together with the byte that follows it and the current A, X, Y, SP and P values, the slice works out the new register values. It raises a write enable for each register it changes. The issue cycle plus one execute cycle gives the two-cycle timing of these one-byte instructions.

The slice covers six cases: setting the overflow flag, an unsigned 8x8 multiply whose 16-bit product is split across A and Y, a load of a fixed diagnostic byte into A, and a scramble that fills all five registers from an internal 16-bit LFSR. Every remaining halt-class opcode, including the reserved prefix 0x92, runs as a no-op. The block also recognises the immediate no-op 0xE2 followed by one exact operand, 0x42, and sets V for that pair only, so software can tell which processor it is running on. On silicon the LFSR powers up in a random state. Here that state comes from a seed input, with one bit forced to 1 by reset.

Top module: `opx_exec_unit`

## Requirements
- R1: An opcode presented with `issue_valid` high at a clock edge produces `wb_valid` high during exactly the cycle that follows the next edge. Issues on consecutive cycles each produce their own result on consecutive cycles.
- R2: Opcode 0x12 writes P with bit 6 (V) set and all other P bits unchanged. P is the only register written.
- R3: Opcode 0xB2 forms the unsigned product A*Y. It writes the low byte to A and the high byte to Y.
- R4: After 0xB2, P bit 1 (Z) is 1 exactly when the product is zero and P bit 7 (N) equals bit 7 of the new Y. All other P bits are unchanged, and only A, Y and P are written.
- R5: Opcode 0x02 writes parameter `DEBUG_BYTE` (default 0xA5) into A and writes nothing else.
- R6: Opcode 0xF2 writes A, X, Y, SP and P, in that order, with five successive LFSR bytes. One byte is the low 8 bits of the state after 8 further steps. One step is s <= {s[14:0], parity(s & 0xD008)}.
- R7: Reset loads the LFSR with {lfsr_seed[15:1], 1}. The state advances only on 0xF2, so a later 0xF2 continues from where the previous one stopped.
- R8: The halt-class opcodes 0x22, 0x32, 0x42, 0x52, 0x62, 0x72, 0x92 and 0xD2 report `wb_claimed` = 1 with no write enable set.
- R9: 0xE2 followed by 0x42 writes P with V set and the other bits unchanged. 0xE2 with any other operand is claimed and writes nothing.
- R10: Opcodes outside the halt class and 0xE2 report `wb_claimed` = 0 with no write enable set.
- R11: While reset is held, and on every cycle without `wb_valid`, all write enables and `wb_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| lfsr_seed | input | 16 | Power-up state of the LFSR bits that reset does not set |
| issue_valid | input | 1 | Opcode and operands are presented this cycle |
| issue_opcode | input | 8 | Fetched opcode |
| issue_imm | input | 8 | Byte following the opcode |
| reg_a | input | 8 | Current accumulator |
| reg_x | input | 8 | Current X index |
| reg_y | input | 8 | Current Y index |
| reg_sp | input | 8 | Current stack pointer |
| reg_p | input | 8 | Current status register |
| wb_valid | output | 1 | Result of an issue two edges earlier |
| wb_claimed | output | 1 | Opcode belongs to this slice |
| a_next | output | 8 | New accumulator |
| x_next | output | 8 | New X |
| y_next | output | 8 | New Y |
| sp_next | output | 8 | New stack pointer |
| p_next | output | 8 | New status register |
| a_we | output | 1 | Write A |
| x_we | output | 1 | Write X |
| y_we | output | 1 | Write Y |
| sp_we | output | 1 | Write SP |
| p_we | output | 1 | Write P |

## Verification
The multiply tests include a product whose low byte is zero but whose high byte is not. A Z flag computed from A alone would set Z there, and a swapped byte order would put 0x01 in A instead of Y. The scramble opcode runs twice with a multiply in between. An LFSR that stepped on every instruction, or that restarted on each scramble, would return the wrong second set of bytes. The detect pair is checked against a neighbouring operand value and against opcode 0x42 carrying operand 0x42. A decoder that matched only one of the two bytes would set V in one of those cases. Back-to-back issues show that a second instruction does not overwrite the first one while it is still executing.

// File: rtl/opx_pkg.sv
package opx_pkg;
  localparam int BYTE_W  = 8;
  localparam int PROD_W  = 2 * BYTE_W;
  localparam int LFSR_W  = 16;
  localparam int N_DRAWS = 5;
  localparam int P_BIT_N = 7;
  localparam int P_BIT_V = 6;
  localparam int P_BIT_Z = 1;

  typedef enum logic [2:0] {
    OPC_NONE,
    OPC_NOP,
    OPC_SEV,
    OPC_MUL,
    OPC_CHIRP,
    OPC_SCRAMBLE,
    OPC_DETECT
  } opc_e;

  function automatic logic [PROD_W-1:0] mul_product(input logic [BYTE_W-1:0] a,
                                                    input logic [BYTE_W-1:0] y);
    return PROD_W'(a) * PROD_W'(y);
  endfunction

  function automatic logic [BYTE_W-1:0] mul_flags(input logic [BYTE_W-1:0] p,
                                                  input logic [PROD_W-1:0] prod);
    logic [BYTE_W-1:0] r;
    r = p;
    r[P_BIT_Z] = (prod == '0);
    r[P_BIT_N] = prod[PROD_W-1];
    return r;
  endfunction

  function automatic logic [BYTE_W-1:0] set_v(input logic [BYTE_W-1:0] p);
    logic [BYTE_W-1:0] r;
    r = p;
    r[P_BIT_V] = 1'b1;
    return r;
  endfunction

  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s,
                                                  input logic [LFSR_W-1:0] taps);
    return {s[LFSR_W-2:0], ^(s & taps)};
  endfunction

  function automatic logic [LFSR_W-1:0] lfsr_byte_adv(input logic [LFSR_W-1:0] s,
                                                      input logic [LFSR_W-1:0] taps);
    logic [LFSR_W-1:0] t;
    t = s;
    for (int i = 0; i < BYTE_W; i++) t = lfsr_step(t, taps);
    return t;
  endfunction
endpackage

// File: rtl/opx_decode.sv
module opx_decode
  import opx_pkg::*;
#(
  parameter logic [BYTE_W-1:0] DETECT_OP  = 8'hE2,
  parameter logic [BYTE_W-1:0] DETECT_IMM = 8'h42
) (
  input  logic [BYTE_W-1:0] opcode,
  input  logic [BYTE_W-1:0] imm,
  output opc_e              cls,
  output logic              claimed
);
  logic [3:0] hi_nib;
  logic       halt_class;

  assign hi_nib = opcode[7:4];
  // Column x2 holds halt opcodes, except rows 8, A, C and E.
  assign halt_class = (opcode[3:0] == 4'h2) && !(hi_nib[3] && !hi_nib[0]);

  always_comb begin
    cls = OPC_NONE;
    if (halt_class) begin
      unique case (opcode)
        8'h12:   cls = OPC_SEV;
        8'hB2:   cls = OPC_MUL;
        8'h02:   cls = OPC_CHIRP;
        8'hF2:   cls = OPC_SCRAMBLE;
        default: cls = OPC_NOP;
      endcase
    end else if (opcode == DETECT_OP) begin
      cls = (imm == DETECT_IMM) ? OPC_DETECT : OPC_NOP;
    end
  end

  assign claimed = (cls != OPC_NONE);
endmodule

// File: rtl/opx_lfsr.sv
module opx_lfsr
  import opx_pkg::*;
#(
  parameter logic [LFSR_W-1:0] TAPS = 16'hD008
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [LFSR_W-1:0]              seed,
  input  logic                           advance,
  output logic [N_DRAWS-1:0][BYTE_W-1:0] draws
);
  logic [LFSR_W-1:0] state;
  logic [N_DRAWS:0][LFSR_W-1:0] chain;

  assign chain[0] = state;

  for (genvar g = 0; g < N_DRAWS; g++) begin : g_draw
    assign chain[g+1] = lfsr_byte_adv(chain[g], TAPS);
    assign draws[g]   = chain[g+1][BYTE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       state <= {seed[LFSR_W-1:1], 1'b1};
    else if (advance) state <= chain[N_DRAWS];
  end

  assert_lfsr_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);

  assert_lfsr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(state));
endmodule

// File: rtl/opx_exec_unit.sv
module opx_exec_unit
  import opx_pkg::*;
#(
  parameter logic [BYTE_W-1:0] DEBUG_BYTE = 8'hA5,
  parameter logic [LFSR_W-1:0] LFSR_TAPS  = 16'hD008
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LFSR_W-1:0] lfsr_seed,
  input  logic              issue_valid,
  input  logic [BYTE_W-1:0] issue_opcode,
  input  logic [BYTE_W-1:0] issue_imm,
  input  logic [BYTE_W-1:0] reg_a,
  input  logic [BYTE_W-1:0] reg_x,
  input  logic [BYTE_W-1:0] reg_y,
  input  logic [BYTE_W-1:0] reg_sp,
  input  logic [BYTE_W-1:0] reg_p,
  output logic              wb_valid,
  output logic              wb_claimed,
  output logic [BYTE_W-1:0] a_next,
  output logic [BYTE_W-1:0] x_next,
  output logic [BYTE_W-1:0] y_next,
  output logic [BYTE_W-1:0] sp_next,
  output logic [BYTE_W-1:0] p_next,
  output logic              a_we,
  output logic              x_we,
  output logic              y_we,
  output logic              sp_we,
  output logic              p_we
);
  // Issue-side decode
  opc_e dec_cls;
  logic dec_claimed;

  opx_decode u_dec (
    .opcode  (issue_opcode),
    .imm     (issue_imm),
    .cls     (dec_cls),
    .claimed (dec_claimed)
  );

  // Execute stage registers
  logic              ex_valid;
  logic              ex_claimed;
  opc_e              ex_cls;
  logic [BYTE_W-1:0] ex_a, ex_y, ex_p;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ex_valid   <= 1'b0;
      ex_claimed <= 1'b0;
      ex_cls     <= OPC_NONE;
      ex_a       <= '0;
      ex_y       <= '0;
      ex_p       <= '0;
    end else begin
      ex_valid   <= issue_valid;
      ex_claimed <= issue_valid && dec_claimed;
      ex_cls     <= issue_valid ? dec_cls : OPC_NONE;
      ex_a       <= reg_a;
      ex_y       <= reg_y;
      ex_p       <= reg_p;
    end
  end

  // Named internal events
  logic ev_scramble;
  logic ev_mul;
  logic ev_sev;
  assign ev_scramble = ex_valid && (ex_cls == OPC_SCRAMBLE);
  assign ev_mul      = ex_valid && (ex_cls == OPC_MUL);
  assign ev_sev      = ex_valid && (ex_cls == OPC_SEV);

  logic [N_DRAWS-1:0][BYTE_W-1:0] rnd;

  opx_lfsr #(.TAPS(LFSR_TAPS)) u_lfsr (
    .clk     (clk),
    .rst_n   (rst_n),
    .seed    (lfsr_seed),
    .advance (ev_scramble),
    .draws   (rnd)
  );

  logic [PROD_W-1:0] prod;
  assign prod = mul_product(ex_a, ex_y);

  // Result formation
  logic [BYTE_W-1:0] c_a, c_x, c_y, c_sp, c_p;
  logic [4:0]        c_we;   // {p, sp, y, x, a}

  always_comb begin
    c_a  = '0;
    c_x  = '0;
    c_y  = '0;
    c_sp = '0;
    c_p  = ex_p;
    c_we = '0;
    unique case (ex_cls)
      OPC_SEV, OPC_DETECT: begin
        c_p  = set_v(ex_p);
        c_we = 5'b10000;
      end
      OPC_MUL: begin
        c_a  = prod[BYTE_W-1:0];
        c_y  = prod[PROD_W-1:BYTE_W];
        c_p  = mul_flags(ex_p, prod);
        c_we = 5'b10101;
      end
      OPC_CHIRP: begin
        c_a  = DEBUG_BYTE;
        c_we = 5'b00001;
      end
      OPC_SCRAMBLE: begin
        c_a  = rnd[0];
        c_x  = rnd[1];
        c_y  = rnd[2];
        c_sp = rnd[3];
        c_p  = rnd[4];
        c_we = 5'b11111;
      end
      default: c_we = '0;
    endcase
    if (!ex_valid) c_we = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_valid   <= 1'b0;
      wb_claimed <= 1'b0;
      a_next     <= '0;
      x_next     <= '0;
      y_next     <= '0;
      sp_next    <= '0;
      p_next     <= '0;
      {p_we, sp_we, y_we, x_we, a_we} <= '0;
    end else begin
      wb_valid   <= ex_valid;
      wb_claimed <= ex_claimed;
      a_next     <= c_a;
      x_next     <= c_x;
      y_next     <= c_y;
      sp_next    <= c_sp;
      p_next     <= c_p;
      {p_we, sp_we, y_we, x_we, a_we} <= c_we;
    end
  end

  // Event flags delayed to line up with the write-back outputs
  logic wb_mul, wb_sev;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_mul <= 1'b0;
      wb_sev <= 1'b0;
    end else begin
      wb_mul <= ev_mul;
      wb_sev <= ev_sev;
    end
  end

  assert_wb_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(issue_valid, 2));

  assert_we_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_valid |-> !(a_we || x_we || y_we || sp_we || p_we));

  assert_sev_only_v_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wb_sev |-> (p_we && !a_we && !y_we && p_next == ($past(reg_p, 2) | 8'h40)));

  assert_mul_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wb_mul |-> (p_next[P_BIT_Z] == (a_next == '0 && y_next == '0)));

  assert_mul_neg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wb_mul |-> (p_next[P_BIT_N] == y_next[BYTE_W-1]));
endmodule

// File: tb/sim_opx_exec_unit.sv
module sim_opx_exec_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] lfsr_seed = 16'hACE0;
  logic        issue_valid = 1'b0;
  logic [7:0]  issue_opcode = '0, issue_imm = '0;
  logic [7:0]  reg_a = '0, reg_x = '0, reg_y = '0, reg_sp = '0, reg_p = '0;
  logic        wb_valid, wb_claimed;
  logic [7:0]  a_next, x_next, y_next, sp_next, p_next;
  logic        a_we, x_we, y_we, sp_we, p_we;

  int checks = 0;
  int fails  = 0;
  logic [15:0] model_lfsr;

  always #10 clk = ~clk;

  opx_exec_unit u0 (.*);

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] m_step(input logic [15:0] s);
    logic fb;
    fb = s[15] ^ s[14] ^ s[12] ^ s[3];
    return {s[14:0], fb};
  endfunction

  function automatic logic [7:0] m_draw();
    for (int k = 0; k < 8; k++) model_lfsr = m_step(model_lfsr);
    return model_lfsr[7:0];
  endfunction

  // Drive at a falling edge; returns at the falling edge where the result shows.
  task automatic issue(input logic [7:0] op, imm, a, x, y, sp, p);
    @(negedge clk);
    issue_opcode = op; issue_imm = imm;
    reg_a = a; reg_x = x; reg_y = y; reg_sp = sp; reg_p = p;
    issue_valid = 1'b1;
    @(negedge clk);
    issue_valid = 1'b0;
    chk("R1 early wb_valid", 16'(wb_valid), 16'h0);
    @(negedge clk);
    chk("R1 wb_valid", 16'(wb_valid), 16'h1);
  endtask

  function automatic logic [4:0] wes();
    return {p_we, sp_we, y_we, x_we, a_we};
  endfunction

  task automatic t_reset();
    chk("R11 reset wb_valid", 16'(wb_valid), 16'h0);
    chk("R11 reset we", 16'(wes()), 16'h0);
  endtask

  task automatic t_sev();
    issue(8'h12, 8'h00, 8'h11, 8'h22, 8'h33, 8'h44, 8'h00);
    chk("R2 sev p", 16'(p_next), 16'h40);
    chk("R2 sev we", 16'(wes()), 16'b10000);
    issue(8'h12, 8'h00, 8'h11, 8'h22, 8'h33, 8'h44, 8'hBF);
    chk("R2 sev keep bits", 16'(p_next), 16'hFF);
    @(negedge clk);
    chk("R1 pulse ends", 16'(wb_valid), 16'h0);
  endtask

  task automatic t_mul(input logic [7:0] a, y, p);
    logic [15:0] pr;
    logic [7:0]  ep;
    pr = 16'(a) * 16'(y);
    ep = p & 8'h7D;
    if (pr[15]) ep = ep | 8'h80;
    if (pr == 16'h0) ep = ep | 8'h02;
    issue(8'hB2, 8'h00, a, 8'h5A, y, 8'hFD, p);
    chk("R3 mul a", 16'(a_next), 16'(pr[7:0]));
    chk("R3 mul y", 16'(y_next), 16'(pr[15:8]));
    chk("R4 mul p", 16'(p_next), 16'(ep));
    chk("R4 mul we", 16'(wes()), 16'b10101);
  endtask

  task automatic t_chirp();
    issue(8'h02, 8'h00, 8'h00, 8'h01, 8'h02, 8'h03, 8'hC3);
    chk("R5 chirp a", 16'(a_next), 16'hA5);
    chk("R5 chirp we", 16'(wes()), 16'b00001);
  endtask

  task automatic t_scramble();
    logic [7:0] ea, ex, ey, es, ep;
    ea = m_draw(); ex = m_draw(); ey = m_draw(); es = m_draw(); ep = m_draw();
    issue(8'hF2, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    chk("R6 scr a", 16'(a_next), 16'(ea));
    chk("R6 scr x", 16'(x_next), 16'(ex));
    chk("R6 scr y", 16'(y_next), 16'(ey));
    chk("R6 scr sp", 16'(sp_next), 16'(es));
    chk("R6 scr p", 16'(p_next), 16'(ep));
    chk("R6 scr we", 16'(wes()), 16'b11111);
  endtask

  task automatic t_nops();
    logic [7:0] ops [8] = '{8'h22, 8'h32, 8'h42, 8'h52, 8'h62, 8'h72, 8'h92, 8'hD2};
    foreach (ops[i]) begin
      issue(ops[i], 8'h42, 8'h01, 8'h02, 8'h03, 8'h04, 8'h00);
      chk("R8 halt nop claimed", 16'(wb_claimed), 16'h1);
      chk("R8 halt nop we", 16'(wes()), 16'h0);
    end
  endtask

  task automatic t_detect();
    issue(8'hE2, 8'h42, 8'h00, 8'h00, 8'h00, 8'h00, 8'h81);
    chk("R9 detect p", 16'(p_next), 16'hC1);
    chk("R9 detect we", 16'(wes()), 16'b10000);
    issue(8'hE2, 8'h43, 8'h00, 8'h00, 8'h00, 8'h00, 8'h81);
    chk("R9 near imm claimed", 16'(wb_claimed), 16'h1);
    chk("R9 near imm we", 16'(wes()), 16'h0);
  endtask

  task automatic t_foreign();
    issue(8'hEA, 8'h42, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    chk("R10 foreign claimed", 16'(wb_claimed), 16'h0);
    chk("R10 foreign we", 16'(wes()), 16'h0);
    issue(8'hA2, 8'h42, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    chk("R10 immediate row claimed", 16'(wb_claimed), 16'h0);
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    issue_opcode = 8'h12; reg_p = 8'h00; issue_valid = 1'b1;
    @(negedge clk);
    issue_opcode = 8'h02; reg_p = 8'h00;
    @(negedge clk);
    issue_valid = 1'b0;
    chk("R1 b2b first p_we", 16'(p_we), 16'h1);
    chk("R1 b2b first p", 16'(p_next), 16'h40);
    @(negedge clk);
    chk("R1 b2b second valid", 16'(wb_valid), 16'h1);
    chk("R1 b2b second a", 16'(a_next), 16'hA5);
    chk("R1 b2b second p_we", 16'(p_we), 16'h0);
  endtask

  initial begin : watchdog
    #(20 * 20000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    model_lfsr = {lfsr_seed[15:1], 1'b1};   // R7 reset state
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_sev();
    t_mul(8'h00, 8'h37, 8'h3C);
    t_mul(8'hFF, 8'hFF, 8'h00);
    t_mul(8'h10, 8'h10, 8'hFF);
    t_chirp();
    t_scramble();
    t_mul(8'h07, 8'h09, 8'h00);
    t_scramble();                             // R7 continues, no advance from other ops
    t_nops();
    t_detect();
    t_foreign();
    t_back_to_back();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule